// File: doc/BRIEF.md
# Page Write Buffer with Write-Cycle Timer

This block gathers the data bytes of one page program operation in a small latch and then runs a timed, non-interruptible write cycle into a byte-wide storage array model. A front end (the serial command decoder, which sits outside this block) first hands over a start address. It then presents one strobe per received data byte. At the end it issues either a commit strobe, which starts the write cycle, or a cancel strobe, which discards the batch.

Each loaded byte goes to the current in-page offset, and only the low offset bits then advance, so the page stays fixed and the offset wraps at the page end. A byte loaded at an offset that already holds a byte replaces it. Every buffered byte carries a valid flag, and only flagged offsets are copied into the array. After a commit, `busy` stays high for a parameterised number of clock cycles that stands in for the physical programming time. The array changes on the very cycle that `busy` drops. While the cycle runs, every control input is ignored. The array can be read at any time through an asynchronous read port.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy` is 0 and every array byte reads 8'hFF.
- R2: A commit while idle (and without cancel) raises `busy` at the next clock edge, and `busy` then stays high for exactly WRITE_CYCLES clock cycles.
- R3: While `busy` is high the array contents do not change. The buffered bytes appear in the array on the same edge at which `busy` falls.
- R4: A start strobe loads the page from address bits [ADDR_W-1:5] and the offset from bits [4:0]. Each loaded byte is stored at the current offset, and only the 5 offset bits then increment, wrapping from 31 to 0 without changing the page.
- R5: When more than 32 bytes are loaded, a later byte overwrites the earlier byte at the same offset, and the array receives only the latest value.
- R6: The write cycle updates only the offsets that were loaded since the batch began. All other bytes of the page and of every other page are left unchanged.
- R7: A cancel while idle discards every loaded byte. A later commit with no new bytes leaves the array unchanged. Cancel has priority over a simultaneous commit, which is then not started.
- R8: While `busy` is high, start, byte, commit and cancel strobes have no effect. The cycle always runs to completion, and no byte offered during it is stored.
- R9: A start strobe while idle discards bytes loaded earlier in the batch. When start and byte strobes come together, start wins and the byte is dropped. The offset is not reset by a completed write, so bytes loaded without a new start continue from where the last batch stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Load page and offset from `startAddr`, clear the batch |
| startAddr | input | ADDR_W | Starting byte address of the batch |
| byteValid | input | 1 | Store `byteData` at the current offset |
| byteData | input | 8 | Data byte to buffer |
| commit | input | 1 | Begin the timed write cycle |
| cancel | input | 1 | Discard the buffered batch |
| busy | output | 1 | Write cycle in progress |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Array contents at `rdAddr` (combinational) |

## Verification
A commit strobe sampled at one edge shows up as `busy` high in the half cycle right after that edge. `busy` then holds for WRITE_CYCLES cycles and is low after the WRITE_CYCLES-th following edge. The array read data changes in that same interval, because the read port has no register. The bench drives every strobe for one cycle from a falling edge and samples one falling edge later, so each result is checked in the half cycle where it first becomes due. Strobes injected in the middle of the busy window, and a read during it, show that nothing moves before the cycle ends.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Strobes from the control FSM to the datapath, at most one action per edge.
  typedef struct packed {
    logic setAddr;
    logic loadByte;
    logic clearValid;
    logic doWrite;
  } pwbStrobe_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int WRITE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       byteValid,
  input  logic       commit,
  input  logic       cancel,
  output logic       busy,
  output pwbStrobe_t strobe
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             lastCycle;
  logic             launch;

  assign lastCycle = busyQ && (cntQ == '0);
  assign launch    = !busyQ && !cancel && commit;
  assign busy      = busyQ;

  // Priority while idle: cancel, commit, start, byte.
  always_comb begin
    strobe = '0;
    if (busyQ) begin
      strobe.doWrite    = lastCycle;
      strobe.clearValid = lastCycle;
    end else if (cancel) begin
      strobe.clearValid = 1'b1;
    end else if (commit) begin
      strobe = '0;
    end else if (startValid) begin
      strobe.setAddr    = 1'b1;
      strobe.clearValid = 1'b1;
    end else if (byteValid) begin
      strobe.loadByte   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (launch) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_LOAD;
    end else if (busyQ) begin
      if (lastCycle) busyQ <= 1'b0;
      else           cntQ  <= cntQ - 1'b1;
    end
  end
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [ADDR_W-1:OFF_W]  pageQ;
  logic [OFF_W-1:0]       offQ;
  logic [PAGE_BYTES-1:0]  bufValid;
  logic [DATA_W-1:0]      bufData [PAGE_BYTES];
  logic [DATA_W-1:0]      mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      offQ  <= '0;
    end else if (strobe.setAddr) begin
      pageQ <= startAddr[ADDR_W-1:OFF_W];
      offQ  <= startAddr[OFF_W-1:0];
    end else if (strobe.loadByte) begin
      offQ  <= offQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  bufValid       <= '0;
    else if (strobe.clearValid) bufValid       <= '0;
    else if (strobe.loadByte)   bufValid[offQ] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.loadByte) bufData[offQ] <= byteData;
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mem[w] <= ERASED;
      else if (strobe.doWrite && (pageQ == WADDR[ADDR_W-1:OFF_W])
               && bufValid[WADDR[OFF_W-1:0]])
        mem[w] <= bufData[WADDR[OFF_W-1:0]];
    end
  end

  assign rdData = mem[rdAddr];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              commit,
  input  logic              cancel,
  output logic              busy,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  pwbStrobe_t strobe;

  pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .byteValid(byteValid),
    .commit(commit), .cancel(cancel), .busy(busy), .strobe(strobe)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .byteData(byteData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W       = 10,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              commit,
  input logic              cancel,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  logic [31:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= '0;
  end

  assert_commit_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && commit && !cancel) |=> busy);

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < 32'(WRITE_CYCLES)));

  assert_no_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (runLen != 32'(WRITE_CYCLES - 1))) |=> busy);

  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (!commit || cancel)) |=> !busy);

  assert_array_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $stable(rdAddr)) |-> $stable(rdData));
endmodule

bind page_write_buffer pwb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .commit(commit), .cancel(cancel),
  .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/sim_page_write_buffer.sv
`timescale 1ns/1ps
module sim_page_write_buffer;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PB     = 32;
  localparam int WCYC   = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startValid = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic             byteValid = 1'b0;
  logic [7:0]       byteData = '0;
  logic             commit = 1'b0;
  logic             cancel = 1'b0;
  logic             busy;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]       rdData;

  int checks = 0;
  int fails  = 0;

  logic [7:0] expMem [DEPTH];
  logic [7:0] mData  [PB];
  logic       mValid [PB];
  int         mPage = 0;
  int         mOff  = 0;

  always #2.5 clk = ~clk;

  page_write_buffer #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WCYC)) u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .commit(commit), .cancel(cancel),
    .busy(busy), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void mClear();
    for (int i = 0; i < PB; i++) mValid[i] = 1'b0;
  endfunction

  function automatic void mFlush();
    for (int i = 0; i < PB; i++)
      if (mValid[i]) expMem[mPage*PB + i] = mData[i];
    mClear();
  endfunction

  task automatic doStart(input int a);
    @(negedge clk); startValid = 1'b1; startAddr = ADDR_W'(a);
    @(negedge clk); startValid = 1'b0;
    mPage = a / PB; mOff = a % PB; mClear();
  endtask

  task automatic doByte(input logic [7:0] d);
    @(negedge clk); byteValid = 1'b1; byteData = d;
    @(negedge clk); byteValid = 1'b0;
    mData[mOff] = d; mValid[mOff] = 1'b1; mOff = (mOff + 1) % PB;
  endtask

  task automatic doCancel();
    @(negedge clk); cancel = 1'b1;
    @(negedge clk); cancel = 1'b0;
    mClear();
  endtask

  task automatic readChk(input string req, input int a);
    rdAddr = ADDR_W'(a);
    #0.5;
    check(req, int'(rdData), int'(expMem[a]));
  endtask

  task automatic checkPage(input string req, input int pg);
    for (int i = 0; i < PB; i++) readChk(req, pg*PB + i);
  endtask

  // Commit, follow busy edge by edge, optionally poke strobes mid-cycle.
  task automatic doCommit(input bit inject);
    int probe;
    probe = mPage*PB;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    check("R2 busy rises", int'(busy), 1);
    for (int i = 1; i < WCYC; i++) begin
      @(negedge clk);
      if (inject && i == 2) begin
        startValid = 1'b1; startAddr = ADDR_W'((mPage+3)*PB);
        byteValid = 1'b1; byteData = 8'h5A; cancel = 1'b1; commit = 1'b1;
      end else begin
        startValid = 1'b0; byteValid = 1'b0; cancel = 1'b0; commit = 1'b0;
      end
      if (i == 4) readChk("R3 array held while busy", probe);
      check("R2 busy held", int'(busy), 1);
    end
    @(negedge clk);
    check("R2 busy falls", int'(busy), 0);
    mFlush();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'hFF;
    mClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy after reset", int'(busy), 0);
    readChk("R1 erased", 0); readChk("R1 erased", 517); readChk("R1 erased", DEPTH-1);

    // R4 offset wrap inside page 5, page 6 untouched
    doStart(5*PB + 30);
    doByte(8'h11); doByte(8'h22); doByte(8'h33); doByte(8'h44);
    doCommit(1'b0);
    readChk("R4 offset 30", 5*PB + 30); readChk("R4 offset 1", 5*PB + 1);
    readChk("R4 wrap stays in page", 6*PB);
    checkPage("R4 page 5", 5);

    // R5 overflow: 35 bytes, offsets 0..2 hold the last three
    doStart(2*PB);
    for (int i = 0; i < 35; i++) doByte(8'(i + 8'h40));
    doCommit(1'b0);
    check("R5 overwrite offset 0", int'(expMem[2*PB]), 8'h60);
    checkPage("R5 page 2", 2);

    // R6 sparse write
    doStart(7*PB + 10);
    doByte(8'hA1); doByte(8'hA2); doByte(8'hA3);
    doCommit(1'b0);
    checkPage("R6 unloaded offsets unchanged", 7);
    readChk("R6 other page", 8*PB + 10);

    // R7 cancel then commit
    doStart(9*PB);
    doByte(8'hC1); doByte(8'hC2);
    doCancel();
    doCommit(1'b0);
    checkPage("R7 cancelled batch not written", 9);
    // R7 cancel with commit same cycle: no cycle starts
    doStart(9*PB); doByte(8'hC3);
    @(negedge clk); cancel = 1'b1; commit = 1'b1;
    @(negedge clk); cancel = 1'b0; commit = 1'b0;
    mClear();
    check("R7 cancel beats commit", int'(busy), 0);

    // R8 strobes during busy ignored
    doStart(11*PB + 4);
    doByte(8'hB4);
    doCommit(1'b1);
    checkPage("R8 page 11", 11);
    checkPage("R8 start during busy ignored", 14);
    doCommit(1'b0);
    checkPage("R8 byte during busy not stored", 11);

    // R9 restart discards, start beats byte, offset continues after write
    doStart(12*PB);
    doByte(8'hD0); doByte(8'hD1);
    @(negedge clk); startValid = 1'b1; startAddr = ADDR_W'(12*PB + 20);
    byteValid = 1'b1; byteData = 8'hEE;
    @(negedge clk); startValid = 1'b0; byteValid = 1'b0;
    mPage = 12; mOff = 20; mClear();
    doByte(8'hD2);
    doCommit(1'b0);
    checkPage("R9 restart discards", 12);
    doByte(8'hD3);
    doCommit(1'b0);
    readChk("R9 offset continues", 12*PB + 21);

    // random batches
    for (int r = 0; r < 30; r++) begin
      int a; int n;
      a = int'($urandom % DEPTH);
      n = 1 + int'($urandom % 40);
      doStart(a);
      for (int k = 0; k < n; k++) doByte(8'($urandom));
      if (($urandom % 8) == 0) doCancel();
      doCommit(($urandom % 4) == 0);
      checkPage("R4 R5 R6 random page", a / PB);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule